// File: doc/BRIEF.md
# Vector Index Conflict Detector

This block receives a vector of lane indices and finds, for every lane, which older lanes carry the same index. Lane j's result is a bit mask in which bit i is set when lane i, numbered below j, holds an equal index. Loops that gather an element, modify it and scatter it back use this to avoid losing updates when two lanes hit the same address. The comparison is triangular. A lane looks only at lanes numbered below it, so the first occurrence of a value never reports a conflict. Each result element is written under a per-lane write mask. A clear mask bit either keeps the element's previous value or forces it to zero, depending on a mode input.

The block also gives a leading-zero count for every result element. Subtracting that count from 31 gives the nearest older lane with the same index, or -1 when there is none. A helper output returns the largest conflict-free subset of a pending-lane set. Software clears that subset from the pending set with XOR and repeats until the set is empty. All outputs are registered one cycle after the inputs.

Top module: `idx_conflict_unit`

## Requirements
- R1: For each lane j whose write-mask bit is set, bit i of result element j is 1 exactly when i < j and index i equals index j, compared over all IDX_W bits.
- R2: Result element 0 is always zero, and in element j every bit at position j or above is zero.
- R3: Result element j occupies conf_o[j*IDX_W +: IDX_W], and bit i of that element stands for lane i, counted from the least significant bit.
- R4: When a lane's write-mask bit is 0 and zero_mode_i is 0 (merge), that lane's result element keeps its previous value.
- R5: When a lane's write-mask bit is 0 and zero_mode_i is 1 (zeroing), that lane's result element becomes zero.
- R6: lz_o[j*LZ_W +: LZ_W] holds the number of leading zero bits of result element j over IDX_W bits. This count is IDX_W exactly when the element is zero, and 31 minus the count is the highest older lane with an equal index.
- R7: free_o bit j is 1 exactly when pend_i bit j is 1 and no lower lane i with pend_i bit i set holds the same index. The write mask and zero_mode_i have no effect on free_o. A lane that is not pending neither appears in free_o nor blocks another lane.
- R8: free_o always contains the lowest pending lane. Replacing the pending set with pend XOR free empties any starting set in at most LANES steps.
- R9: Every output reflects the inputs of the previous clock edge. While rst_ni is low, conf_o is zero, every lz_o field equals IDX_W, and free_o is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| idx_i | input | LANES*IDX_W | Index vector; lane j is at bits [j*IDX_W +: IDX_W] |
| wmask_i | input | LANES | Destination write mask, one bit per lane |
| zero_mode_i | input | 1 | 1: clear masked-off lanes; 0: keep their previous element |
| pend_i | input | LANES | Lanes still waiting to be processed |
| conf_o | output | LANES*IDX_W | Conflict mask per lane |
| lz_o | output | LANES*LZ_W | Leading-zero count of each result element, LZ_W = clog2(IDX_W+1) |
| free_o | output | LANES | Conflict-free subset of pend_i |

## Verification
On every cycle the assertions check the following. Result bits on or above the diagonal stay zero. Masked-off lanes hold their value in merge mode and read zero in zeroing mode. Each count is IDX_W exactly when its element is zero. The subset never leaves the pending set and always contains the lowest pending lane. Only the bench's reference model, running over many index patterns, can show that each conflict bit marks a real equal pair and that counts and subsets are exact. These patterns are all distinct, all equal, repeating short runs, and random values drawn from a small range. The claim that the XOR iteration empties the pending set within LANES steps is shown by driving the loop through the ports.

// File: rtl/cd_pkg.sv
package cd_pkg;
  typedef enum logic {
    WR_MERGE = 1'b0,
    WR_ZERO  = 1'b1
  } wr_mode_e;
endpackage

// File: rtl/cd_match_matrix.sv
module cd_match_matrix #(
  parameter int LANES = 16,
  parameter int IDX_W = 32
) (
  input  logic [LANES*IDX_W-1:0] idx_i,
  output logic [LANES*LANES-1:0] hit_o   // row j, bit i: older lane i matches lane j
);
  for (genvar j = 0; j < LANES; j++) begin : g_row
    for (genvar i = 0; i < LANES; i++) begin : g_col
      if (i < j) begin : g_cmp
        assign hit_o[j*LANES+i] = (idx_i[i*IDX_W +: IDX_W] == idx_i[j*IDX_W +: IDX_W]);
      end else begin : g_none
        assign hit_o[j*LANES+i] = 1'b0;
      end
    end
  end
endmodule

// File: rtl/cd_subset.sv
module cd_subset #(
  parameter int LANES = 16
) (
  input  logic [LANES*LANES-1:0] hit_i,
  input  logic [LANES-1:0]       pend_i,
  output logic [LANES-1:0]       free_o
);
  for (genvar j = 0; j < LANES; j++) begin : g_lane
    // blocked only by a pending older lane with the same index
    assign free_o[j] = pend_i[j] & ~|(hit_i[j*LANES +: LANES] & pend_i);
  end
endmodule

// File: rtl/cd_lzc.sv
module cd_lzc #(
  parameter int W  = 32,
  parameter int CW = $clog2(W + 1)
) (
  input  logic [W-1:0]  val_i,
  output logic [CW-1:0] cnt_o
);
  always_comb begin
    logic found;
    found = 1'b0;
    cnt_o = CW'(W);
    for (int k = W - 1; k >= 0; k--) begin
      if (!found && val_i[k]) begin
        cnt_o = CW'(W - 1 - k);
        found = 1'b1;
      end
    end
  end
endmodule

// File: rtl/idx_conflict_unit.sv
module idx_conflict_unit #(
  parameter int LANES = 16,
  parameter int IDX_W = 32
) (
  input  logic                                 clk_i,
  input  logic                                 rst_ni,
  input  logic [LANES*IDX_W-1:0]               idx_i,
  input  logic [LANES-1:0]                     wmask_i,
  input  logic                                 zero_mode_i,
  input  logic [LANES-1:0]                     pend_i,
  output logic [LANES*IDX_W-1:0]               conf_o,
  output logic [LANES*$clog2(IDX_W+1)-1:0]     lz_o,
  output logic [LANES-1:0]                     free_o
);
  import cd_pkg::*;

  localparam int ELEM_W = IDX_W;
  localparam int LZ_W   = $clog2(IDX_W + 1);

  logic [LANES*LANES-1:0]  hit;
  logic [LANES*ELEM_W-1:0] dest_d;
  logic [LANES*LZ_W-1:0]   lz_d;
  logic [LANES-1:0]        free_d;
  wr_mode_e                mode;

  assign mode = wr_mode_e'(zero_mode_i);

  cd_match_matrix #(.LANES(LANES), .IDX_W(IDX_W)) u_match (
    .idx_i (idx_i),
    .hit_o (hit)
  );

  cd_subset #(.LANES(LANES)) u_subset (
    .hit_i  (hit),
    .pend_i (pend_i),
    .free_o (free_d)
  );

  for (genvar j = 0; j < LANES; j++) begin : g_lane
    logic [ELEM_W-1:0] row;
    assign row = ELEM_W'(hit[j*LANES +: LANES]);

    always_comb begin
      if (wmask_i[j])           dest_d[j*ELEM_W +: ELEM_W] = row;
      else if (mode == WR_ZERO) dest_d[j*ELEM_W +: ELEM_W] = '0;
      else                      dest_d[j*ELEM_W +: ELEM_W] = conf_o[j*ELEM_W +: ELEM_W];
    end

    cd_lzc #(.W(ELEM_W), .CW(LZ_W)) u_lzc (
      .val_i (dest_d[j*ELEM_W +: ELEM_W]),
      .cnt_o (lz_d[j*LZ_W +: LZ_W])
    );

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        conf_o[j*ELEM_W +: ELEM_W] <= '0;
        lz_o[j*LZ_W +: LZ_W]       <= LZ_W'(ELEM_W);
      end else begin
        conf_o[j*ELEM_W +: ELEM_W] <= dest_d[j*ELEM_W +: ELEM_W];
        lz_o[j*LZ_W +: LZ_W]       <= lz_d[j*LZ_W +: LZ_W];
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) free_o <= '0;
    else         free_o <= free_d;
  end
endmodule

// File: rtl/cd_checker.sv
module cd_checker #(
  parameter int LANES = 16,
  parameter int IDX_W = 32,
  parameter int LZ_W  = $clog2(IDX_W + 1)
) (
  input logic                   clk_i,
  input logic                   rst_ni,
  input logic [LANES-1:0]       wmask_i,
  input logic                   zero_mode_i,
  input logic [LANES-1:0]       pend_i,
  input logic [LANES*IDX_W-1:0] conf_o,
  input logic [LANES*LZ_W-1:0]  lz_o,
  input logic [LANES-1:0]       free_o
);
  logic armed;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) armed <= 1'b0;
    else         armed <= 1'b1;
  end

  for (genvar j = 0; j < LANES; j++) begin : g_chk
    p_upper_zero_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
      conf_o[j*IDX_W + j +: IDX_W - j] == '0);

    p_merge_hold_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
      armed && !$past(wmask_i[j]) && !$past(zero_mode_i)
      |-> conf_o[j*IDX_W +: IDX_W] == $past(conf_o[j*IDX_W +: IDX_W]));

    p_zeroing_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      armed && !$past(wmask_i[j]) && $past(zero_mode_i)
      |-> conf_o[j*IDX_W +: IDX_W] == '0);

    p_lz_full_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (conf_o[j*IDX_W +: IDX_W] == '0) == (lz_o[j*LZ_W +: LZ_W] == LZ_W'(IDX_W)));
  end

  p_free_in_pend_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    armed |-> (free_o & ~$past(pend_i)) == '0);

  p_lowest_free_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    armed && $past(pend_i) != '0
    |-> (free_o & $past(pend_i) & (~$past(pend_i) + LANES'(1))) != '0);
endmodule

bind idx_conflict_unit cd_checker #(.LANES(LANES), .IDX_W(IDX_W)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .wmask_i     (wmask_i),
  .zero_mode_i (zero_mode_i),
  .pend_i      (pend_i),
  .conf_o      (conf_o),
  .lz_o        (lz_o),
  .free_o      (free_o)
);

// File: tb/idx_conflict_unit_test.sv
module idx_conflict_unit_test;
  localparam int PERIOD = 10;
  localparam int LANES  = 16;
  localparam int IDX_W  = 32;
  localparam int LZ_W   = $clog2(IDX_W + 1);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [LANES*IDX_W-1:0] idx_i = '0;
  logic [LANES-1:0] wmask_i = '0;
  logic zero_mode_i = 1'b0;
  logic [LANES-1:0] pend_i = '0;
  logic [LANES*IDX_W-1:0] conf_o;
  logic [LANES*LZ_W-1:0] lz_o;
  logic [LANES-1:0] free_o;

  always #(PERIOD/2) clk = ~clk;

  idx_conflict_unit #(.LANES(LANES), .IDX_W(IDX_W)) uut (
    .clk_i(clk), .rst_ni(rst_n), .idx_i(idx_i), .wmask_i(wmask_i),
    .zero_mode_i(zero_mode_i), .pend_i(pend_i),
    .conf_o(conf_o), .lz_o(lz_o), .free_o(free_o)
  );

  int checks = 0;
  int errors = 0;
  bit done = 0;

  // stimulus held in bench variables
  logic [IDX_W-1:0] v [LANES];
  logic [LANES-1:0] wm, pd;
  logic zm;

  // reference state
  logic [IDX_W-1:0] exp_conf [LANES];
  int exp_lz [LANES];
  logic [LANES-1:0] exp_free;
  string tag [LANES];

  task automatic chk(input string req, input longint got, input longint exp);
    checks++;
    if (got != exp) begin
      errors++;
      $display("FAIL %s got %0h expected %0h", req, got, exp);
    end
  endtask

  function automatic int lead_zeros(input logic [IDX_W-1:0] x);
    for (int k = IDX_W - 1; k >= 0; k--) if (x[k]) return IDX_W - 1 - k;
    return IDX_W;
  endfunction

  task automatic compare();
    for (int j = 0; j < LANES; j++) begin
      chk(tag[j], conf_o[j*IDX_W +: IDX_W], exp_conf[j]);
      chk("R6 lz", lz_o[j*LZ_W +: LZ_W], exp_lz[j]);
    end
    chk("R7 free", free_o, exp_free);
  endtask

  task automatic tick();
    @(negedge clk);
    compare();
  endtask

  // apply held stimulus and advance the reference by one clock
  task automatic drive();
    for (int j = 0; j < LANES; j++) idx_i[j*IDX_W +: IDX_W] = v[j];
    wmask_i = wm; zero_mode_i = zm; pend_i = pd;
    for (int j = 0; j < LANES; j++) begin
      logic [IDX_W-1:0] e;
      logic blocked;
      e = '0;
      blocked = 1'b0;
      for (int i = 0; i < j; i++) begin
        if (v[i] == v[j]) begin
          e[i] = 1'b1;
          if (pd[i]) blocked = 1'b1;
        end
      end
      if (wm[j]) begin
        exp_conf[j] = e;
        tag[j] = (j == 0) ? "R2 lane0" : "R1 R3 conf";
      end else if (zm) begin
        exp_conf[j] = '0;
        tag[j] = "R5 zeroing";
      end else begin
        tag[j] = "R4 merge";
      end
      exp_lz[j] = lead_zeros(exp_conf[j]);
      exp_free[j] = pd[j] && !blocked;
    end
  endtask

  task automatic step();
    drive();
    tick();
  endtask

  task automatic summary();
    if (!done) begin
      done = 1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    #(PERIOD * 100000);
    errors++;
    $display("FAIL watchdog expired");
    summary();
  end

  initial begin
    for (int j = 0; j < LANES; j++) begin
      v[j] = '0; exp_conf[j] = '0; exp_lz[j] = IDX_W; tag[j] = "R9 reset";
    end
    exp_free = '0;
    wm = '0; zm = 1'b0; pd = '0;
    #(PERIOD * 3);
    compare();  // R9 reset values
    @(negedge clk);
    rst_n = 1'b1;

    // distinct indices: no conflicts
    for (int j = 0; j < LANES; j++) v[j] = 32'h1000 + j;
    wm = '1; pd = '1; step();
    // all equal: lane j marks every older lane, subset is lane 0 only
    for (int j = 0; j < LANES; j++) v[j] = 32'hDEAD_BEEF;
    step();
    // repeating 2,1,3,2
    for (int j = 0; j < LANES; j++) v[j] = (j % 4 == 0 || j % 4 == 3) ? 2 : (j % 4 == 1 ? 1 : 3);
    step();
    // values differing only in the top bit must not match (R1 full width)
    for (int j = 0; j < LANES; j++) v[j] = {j[0], 31'h5};
    step();
    // merge then zeroing with a sparse mask
    wm = 16'h00F0; zm = 1'b0; for (int j = 0; j < LANES; j++) v[j] = 7; step();
    wm = 16'h0F00; zm = 1'b1; step();
    // pending set ignores non-pending lanes (R7)
    wm = '1; zm = 1'b0; pd = 16'hAAAA; step();

    // random small-range indices, masks, modes
    for (int n = 0; n < 300; n++) begin
      for (int j = 0; j < LANES; j++) v[j] = $urandom_range(0, 5);
      wm = LANES'($urandom); zm = 1'($urandom); pd = LANES'($urandom);
      step();
    end

    // R8: drive pend ^= free through the ports until empty
    for (int t = 0; t < 3; t++) begin
      int steps;
      logic [LANES-1:0] p;
      for (int j = 0; j < LANES; j++) v[j] = (t == 0) ? 9 : $urandom_range(0, 3);
      wm = '1; p = '1; pd = p;
      step();
      steps = 0;
      while (p != '0 && steps <= LANES) begin
        checks++;
        if ((free_o & p & (~p + 1'b1)) == '0) begin
          errors++;
          $display("FAIL R8 lowest pending missing got %0h expected %0h", free_o, p & (~p + 1'b1));
        end
        p = p ^ free_o;
        steps++;
        pd = p;
        step();
      end
      chk("R8 pending empty", p, 0);
      checks++;
      if (steps > LANES) begin
        errors++;
        $display("FAIL R8 steps got %0d expected <= %0d", steps, LANES);
      end
    end
    summary();
  end
endmodule